// File: doc/BRIEF.md
# Transmit Frame Finisher

This block sits on the transmit path between a packet source and the line coding stage. It takes frames on a 64-bit byte-packed stream, first byte in the top byte lane, and finishes each one before it leaves. It can replace the source address with a configured value. It pads frames that are too short with zero bytes, and it appends the four-byte CRC-32 frame check sequence. When a frame needs padding or check bytes beyond its last input beat, the block generates the extra beats itself and holds the input stalled while it does.

A per-frame bypass flag, sampled on the start-of-packet beat, turns off all three steps for that frame, and the frame then passes through byte for byte. Error marking is independent of bypass. A frame of 9 to 13 bytes, or a frame whose client error bit is set on its end beat, is still sent in full, but the block raises a sideband error-control flag on its last output beat so that the coding stage can corrupt it. The check sequence is left correct.

Both stream sides use valid/ready. A beat moves when valid and ready are both high on a rising clock edge. The source must hold a beat stable until it is taken, and it must send a frame with no idle beats between its start and its end. The input ready is high only when the single output register is empty or is being drained in the same cycle, and the block is not generating tail beats. So the input ready depends combinationally on the output ready.

Top module: `txf_frame_finisher`

## Requirements
- R1: While `out_valid` is high and `out_ready` is low, the output beat (data, sop, eop, empty, errctl) holds unchanged, and `in_ready` is low.
- R2: With bypass low and `cfg_sa_ins_en` high, frame bytes 6 to 11 are replaced by `cfg_src_addr`, most significant octet first. On the bus these are beat 0 bits 15:0 (address bits 47:32) and beat 1 bits 63:32 (address bits 31:0). With `cfg_sa_ins_en` low, those bytes pass unchanged.
- R3: With bypass low, a frame shorter than 60 bytes is extended with zero bytes up to 60 bytes before the check sequence. A frame of 60 bytes or more gets no padding.
- R4: With bypass low, the block appends the reflected CRC-32 (polynomial 0xEDB88320, preset all ones, result inverted). The CRC is computed over all data and pad bytes, and its least significant byte is sent first.
- R5: With bypass high, the output frame equals the input frame byte for byte: no insertion, no padding and no check sequence.
- R6: The bypass flag is taken from the start-of-packet beat. Its value on any later beat of the same frame has no effect.
- R7: A frame of 9 to 13 input bytes raises `out_errctl` on its end beat, with or without bypass.
- R8: `in_err` high on an input end beat raises `out_errctl` on that frame's output end beat. Otherwise `out_errctl` stays low.
- R9: Each output frame has `out_sop` on its first beat only and `out_eop` on its last beat only. `out_empty` gives the number of unused low-order byte lanes on the end beat, and it is 0 on every other beat.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sa_ins_en | input | 1 | Enables source address replacement |
| cfg_src_addr | input | 48 | Source address to insert |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts an input beat |
| in_data | input | 64 | Input bytes, first byte in bits 63:56 |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 3 | Unused low lanes on the end beat |
| in_err | input | 1 | Client error request, sampled on the end beat |
| in_bypass | input | 1 | Per-frame bypass, sampled on the start beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 64 | Finished frame bytes |
| out_sop | output | 1 | First output beat of a frame |
| out_eop | output | 1 | Last output beat of a frame |
| out_empty | output | 3 | Unused low lanes on the end beat |
| out_errctl | output | 1 | Frame to be sent as errored, valid on the end beat |

## Verification
The hardest cases to reach are the ones where the check sequence splits across the last data beat and a generated tail beat, and where that tail is generated while the output is back-pressured. The CRC state must survive both the boundary and the stall. Frames of 62 and 63 bytes put the check bytes across a beat boundary. A 72-byte frame needs one whole generated tail beat. Short frames need a run of pure padding beats. Each of these is run under output-ready patterns that stall every other cycle or every third cycle, so tail generation is frozen partway through. Other frames change the bypass flag after the start beat, which shows that only the start-beat value is used.

// File: rtl/txf_pkg.sv
package txf_pkg;
  // Reflected CRC-32 polynomial (bit 0 is the first bit on the wire)
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  // Frame body size before the check sequence when padding applies
  localparam int MIN_BODY  = 60;
  localparam int FCS_LEN   = 4;
  // Byte position and length of the source address inside the frame
  localparam int SA_FIRST  = 6;
  localparam int SA_LEN    = 6;
  // Frame sizes that are sent but flagged as errored
  localparam int ERR_LO    = 9;
  localparam int ERR_HI    = 13;

  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/txf_lane_mux.sv
// Per-lane body builder: picks data, inserted address byte or zero pad.
module txf_lane_mux
  import txf_pkg::*;
#(
  parameter int LANES = 8,
  parameter int POS_W = 14
) (
  input  logic [POS_W-1:0]   base,
  input  logic [POS_W-1:0]   data_lim,
  input  logic [POS_W-1:0]   pad_lim,
  input  logic [8*LANES-1:0] din,
  input  logic               ins_en,
  input  logic [47:0]        src_addr,
  output logic [8*LANES-1:0] body,
  output logic [LANES-1:0]   body_en
);
  localparam logic [POS_W-1:0] SA_LO  = POS_W'(SA_FIRST);
  localparam logic [POS_W-1:0] SA_HI  = POS_W'(SA_FIRST + SA_LEN);
  localparam logic [POS_W-1:0] SA_TOP = POS_W'(SA_FIRST + SA_LEN - 1);

  logic [63:0] sa_wide;
  assign sa_wide = {16'd0, src_addr};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [POS_W-1:0] OFS = POS_W'(i);
    logic [POS_W-1:0] pos;
    logic             is_data;
    logic             is_pad;
    logic             in_sa;
    logic [2:0]       sa_sel;
    logic [7:0]       raw;
    logic [7:0]       sa_byte;

    assign pos     = base + OFS;
    assign is_data = pos < data_lim;
    assign is_pad  = !is_data && (pos < pad_lim);
    assign in_sa   = ins_en && (pos >= SA_LO) && (pos < SA_HI);
    assign sa_sel  = 3'(SA_TOP - pos);
    assign sa_byte = sa_wide[{sa_sel, 3'b000} +: 8];
    assign raw     = din[8*(LANES-1-i) +: 8];
    assign body[8*(LANES-1-i) +: 8] = is_data ? (in_sa ? sa_byte : raw) : 8'h00;
    assign body_en[i] = is_data || is_pad;
  end
endmodule

// File: rtl/txf_crc_lanes.sv
// CRC-32 advanced over the enabled lanes of one beat, lane 0 first.
module txf_crc_lanes
  import txf_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [31:0]        crc_in,
  input  logic [8*LANES-1:0] body,
  input  logic [LANES-1:0]   en,
  output logic [31:0]        crc_out
);
  logic [LANES:0][31:0] chain;
  assign chain[0] = crc_in;

  for (genvar i = 0; i < LANES; i++) begin : g_step
    assign chain[i+1] = en[i] ? crc_step_byte(chain[i], body[8*(LANES-1-i) +: 8]) : chain[i];
  end

  assign crc_out = chain[LANES];
endmodule

// File: rtl/txf_fcs_fill.sv
// Places check-sequence bytes after the body, least significant byte first.
module txf_fcs_fill
  import txf_pkg::*;
#(
  parameter int LANES = 8,
  parameter int POS_W = 14
) (
  input  logic [POS_W-1:0]   base,
  input  logic [POS_W-1:0]   pad_lim,
  input  logic               bypass,
  input  logic [8*LANES-1:0] body,
  input  logic [31:0]        crc_after,
  output logic [8*LANES-1:0] dout
);
  localparam logic [POS_W:0] FCS_P = (POS_W+1)'(FCS_LEN);

  logic [31:0]    fcs;
  logic [POS_W:0] lim_x;
  assign fcs   = ~crc_after;
  assign lim_x = {1'b0, pad_lim};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [POS_W:0] OFS = (POS_W+1)'(i);
    logic [POS_W:0] pos;
    logic           in_body;
    logic           is_fcs;
    logic [1:0]     sel;
    logic [7:0]     fcs_byte;

    assign pos      = {1'b0, base} + OFS;
    assign in_body  = pos < lim_x;
    assign is_fcs   = !bypass && !in_body && (pos < lim_x + FCS_P);
    assign sel      = 2'(pos - lim_x);
    assign fcs_byte = fcs[{sel, 3'b000} +: 8];
    assign dout[8*(LANES-1-i) +: 8] = in_body ? body[8*(LANES-1-i) +: 8] :
                                      is_fcs  ? fcs_byte : 8'h00;
  end
endmodule

// File: rtl/txf_frame_finisher.sv
module txf_frame_finisher
  import txf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int POS_W  = 14
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_sa_ins_en,
  input  logic [47:0]                         cfg_src_addr,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [DATA_W-1:0]                   in_data,
  input  logic                                in_sop,
  input  logic                                in_eop,
  input  logic [$clog2(DATA_W/8)-1:0]         in_empty,
  input  logic                                in_err,
  input  logic                                in_bypass,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [DATA_W-1:0]                   out_data,
  output logic                                out_sop,
  output logic                                out_eop,
  output logic [$clog2(DATA_W/8)-1:0]         out_empty,
  output logic                                out_errctl
);
  localparam int LANES   = DATA_W / 8;
  localparam int EMPTY_W = $clog2(LANES);
  localparam logic [POS_W-1:0] LANE_P = POS_W'(LANES);
  localparam logic [POS_W-1:0] MIN_P  = POS_W'(MIN_BODY);
  localparam logic [POS_W-1:0] ELO_P  = POS_W'(ERR_LO);
  localparam logic [POS_W-1:0] EHI_P  = POS_W'(ERR_HI);
  localparam logic [POS_W:0]   FCS_P  = (POS_W+1)'(FCS_LEN);

  // Frame state
  logic             busy_q;   // inside an input frame
  logic             tail_q;   // generating pad / check beats
  logic             byp_q;
  logic             err_q;
  logic [POS_W-1:0] base_q;
  logic [POS_W-1:0] len_q;
  logic [31:0]      crc_q;

  // Handshake
  logic adv, in_fire, tail_fire, load, start;
  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv && !tail_q;
  assign in_fire   = in_valid && in_ready;
  assign tail_fire = tail_q && adv;
  assign load      = in_fire || tail_fire;
  assign start     = in_fire && in_sop;

  // Current beat context
  logic [POS_W-1:0] cur_base, nvalid, data_lim, pad_lim;
  logic [POS_W:0]   end_pos, beat_top;
  logic             cur_byp, cur_eop, last, short_len, cur_err, ins_eff;
  logic [31:0]      crc_in;
  logic [EMPTY_W-1:0] empty_n;

  assign cur_base  = start ? '0 : base_q;
  assign cur_byp   = start ? in_bypass : byp_q;
  assign crc_in    = start ? 32'hFFFF_FFFF : crc_q;
  assign cur_eop   = tail_q || in_eop;
  assign nvalid    = LANE_P - POS_W'(in_empty);
  assign data_lim  = tail_q ? len_q : (in_eop ? cur_base + nvalid : cur_base + LANE_P);
  assign pad_lim   = (!cur_byp && (data_lim < MIN_P)) ? MIN_P : data_lim;
  assign end_pos   = cur_byp ? {1'b0, data_lim} : ({1'b0, pad_lim} + FCS_P);
  assign beat_top  = {1'b0, cur_base} + {1'b0, LANE_P};
  assign last      = cur_eop && (end_pos <= beat_top);
  assign empty_n   = EMPTY_W'(beat_top - end_pos);
  assign short_len = (data_lim >= ELO_P) && (data_lim <= EHI_P);
  assign cur_err   = tail_q ? err_q : (short_len || in_err);
  assign ins_eff   = cfg_sa_ins_en && !cur_byp;

  // Datapath
  logic [DATA_W-1:0] body, beat_data;
  logic [LANES-1:0]  body_en;
  logic [31:0]       crc_after;

  txf_lane_mux #(.LANES(LANES), .POS_W(POS_W)) u_lane_mux (
    .base     (cur_base),
    .data_lim (data_lim),
    .pad_lim  (pad_lim),
    .din      (in_data),
    .ins_en   (ins_eff),
    .src_addr (cfg_src_addr),
    .body     (body),
    .body_en  (body_en)
  );

  txf_crc_lanes #(.LANES(LANES)) u_crc (
    .crc_in  (crc_in),
    .body    (body),
    .en      (body_en & {LANES{!cur_byp}}),
    .crc_out (crc_after)
  );

  txf_fcs_fill #(.LANES(LANES), .POS_W(POS_W)) u_fill (
    .base      (cur_base),
    .pad_lim   (pad_lim),
    .bypass    (cur_byp),
    .body      (body),
    .crc_after (crc_after),
    .dout      (beat_data)
  );

  // Output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_empty  <= '0;
      out_errctl <= 1'b0;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_data   <= beat_data;
      out_sop    <= !tail_q && (cur_base == '0);
      out_eop    <= last;
      out_empty  <= last ? empty_n : '0;
      out_errctl <= last && cur_err;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // Frame control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tail_q <= 1'b0;
      byp_q  <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
      crc_q  <= 32'hFFFF_FFFF;
    end else if (load) begin
      base_q <= beat_top[POS_W-1:0];
      crc_q  <= crc_after;
      byp_q  <= cur_byp;
      if (in_fire) begin
        busy_q <= !in_eop;
        if (in_eop && !last) begin
          tail_q <= 1'b1;
          len_q  <= data_lim;
          err_q  <= cur_err;
        end
      end
      if (tail_fire && last) tail_q <= 1'b0;
    end
  end

  // Checker state for output framing
  logic           ofrm_q;
  logic [POS_W:0] olen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofrm_q <= 1'b0;
      olen_q <= '0;
    end else if (out_valid && out_ready) begin
      ofrm_q <= !out_eop;
      olen_q <= out_eop ? '0 : olen_q + (POS_W+1)'(LANES);
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eop)
                                && $stable(out_empty) && $stable(out_errctl));

  p_stall_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_byp_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !start |=> $stable(byp_q));

  p_err_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_errctl |-> out_eop);

  p_sop_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sop == !ofrm_q));

  p_empty_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |-> out_empty == '0);

  p_min_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop && !byp_q |->
      (int'(olen_q) + LANES - int'(out_empty)) >= (MIN_BODY + FCS_LEN));
endmodule

// File: tb/txf_frame_finisher_tb_top.sv
`timescale 1ns/1ps
module txf_frame_finisher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sa_ins_en = 1'b0;
  logic [47:0] cfg_src_addr = 48'hA1B2_C3D4_E5F6;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_data = '0;
  logic        in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0, in_bypass = 1'b0;
  logic [2:0]  in_empty = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_sop, out_eop, out_errctl;
  logic [2:0]  out_empty;

  always #10 clk = ~clk;

  txf_frame_finisher dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sa_ins_en(cfg_sa_ins_en), .cfg_src_addr(cfg_src_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_empty(in_empty), .in_err(in_err), .in_bypass(in_bypass),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_empty(out_empty), .out_errctl(out_errctl)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // len, bypass, insert enable, client error, bypass toggled after sop, ready pattern
  typedef struct packed {
    logic [9:0] len;
    logic       byp;
    logic       ins;
    logic       err;
    logic       togg;
    logic [1:0] stall;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{10'd64,  1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    '{10'd60,  1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    '{10'd20,  1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
    '{10'd9,   1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    '{10'd13,  1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    '{10'd14,  1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
    '{10'd61,  1'b0, 1'b1, 1'b1, 1'b0, 2'd1},
    '{10'd100, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2},
    '{10'd12,  1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{10'd62,  1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    '{10'd72,  1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
    '{10'd30,  1'b0, 1'b1, 1'b0, 1'b1, 2'd1},
    '{10'd40,  1'b1, 1'b1, 1'b0, 1'b1, 2'd2},
    '{10'd33,  1'b1, 1'b0, 1'b1, 1'b0, 2'd0}
  };

  logic [7:0] fb [256];
  logic [7:0] eb [256];
  logic [7:0] ob [256];
  int  exp_len;
  int  ocnt;
  bit  odone, oerr, oframe_bad;
  int  r1_bad = 0;
  bit  hold_pend = 1'b0;
  logic [63:0] hold_data;
  logic [1:0]  stall_mode = 2'd0;
  int  cyc = 0;

  // Output ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    case (stall_mode)
      2'd0:    out_ready = 1'b1;
      2'd1:    out_ready = cyc[0];
      default: out_ready = (cyc % 3) != 0;
    endcase
  end

  // Output monitor, sampling at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend && (!out_valid || out_data != hold_data)) r1_bad++;
      hold_pend = 1'b0;
      if (out_valid && !out_ready) begin
        if (in_ready) r1_bad++;
        hold_pend = 1'b1;
        hold_data = out_data;
      end
      if (out_valid && out_ready) begin
        if ((ocnt == 0) != out_sop) oframe_bad = 1'b1;
        if (!out_eop && out_empty != 3'd0) oframe_bad = 1'b1;
        for (int l = 0; l < (out_eop ? 8 - int'(out_empty) : 8); l++) begin
          if (ocnt < 256) ob[ocnt] = out_data[63-8*l -: 8];
          ocnt++;
        end
        if (out_eop) begin
          odone = 1'b1;
          oerr  = out_errctl;
        end
      end
    end
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    logic        fbk;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        fbk = eb[i][b] ^ c[0];
        c = c >> 1;
        if (fbk) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic build_expected(input vec_t v);
    int body_len;
    logic [31:0] f;
    for (int k = 0; k < int'(v.len); k++) eb[k] = fb[k];
    exp_len = int'(v.len);
    if (!v.byp) begin
      if (v.ins)
        for (int k = 6; k < 12; k++)
          if (k < int'(v.len)) eb[k] = cfg_src_addr[8*(11-k) +: 8];
      body_len = (int'(v.len) < 60) ? 60 : int'(v.len);
      for (int k = int'(v.len); k < body_len; k++) eb[k] = 8'h00;
      f = ref_crc(body_len);
      for (int k = 0; k < 4; k++) eb[body_len+k] = f[8*k +: 8];
      exp_len = body_len + 4;
    end
  endtask

  task automatic send_frame(input vec_t v);
    int nb;
    nb = (int'(v.len) + 7) / 8;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sop    = (b == 0);
      in_eop    = (b == nb - 1);
      in_empty  = in_eop ? 3'(nb*8 - int'(v.len)) : 3'd0;
      in_err    = in_eop ? v.err : 1'b0;
      in_bypass = (b == 0) ? v.byp : (v.byp ^ v.togg);
      for (int l = 0; l < 8; l++)
        in_data[63-8*l -: 8] = (b*8 + l < int'(v.len)) ? fb[b*8+l] : 8'hEE;
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0; in_bypass = 1'b0;
  endtask

  task automatic run_vector(input vec_t v, input int idx);
    string tag;
    int    mi;
    int    body_len;
    bit    exp_err;
    for (int k = 0; k < 256; k++) fb[k] = 8'(k*37 + idx*11 + 3);
    cfg_sa_ins_en = v.ins;
    build_expected(v);
    ocnt = 0; odone = 1'b0; oerr = 1'b0; oframe_bad = 1'b0;
    stall_mode = v.stall;
    send_frame(v);
    for (int t = 0; t < 3000 && !odone; t++) @(negedge clk);
    body_len = (int'(v.len) < 60) ? 60 : int'(v.len);

    // Frame length: bypass passthrough, padding or check sequence
    tag = v.togg ? "R6" : (v.byp ? "R5" : (int'(v.len) < 60 ? "R3" : "R4"));
    chk(odone && ocnt == exp_len, tag, $sformatf("vec%0d output length", idx), ocnt, exp_len);

    // Byte content, requirement chosen by the region of the first mismatch
    mi = -1;
    for (int k = 0; k < exp_len && k < ocnt && k < 256; k++)
      if (mi < 0 && ob[k] !== eb[k]) mi = k;
    if (mi < 0) tag = v.togg ? "R6" : (v.byp ? "R5" : "R4");
    else if (v.togg) tag = "R6";
    else if (v.byp) tag = "R5";
    else if (mi >= 6 && mi < 12) tag = "R2";
    else if (mi >= int'(v.len) && mi < body_len) tag = "R3";
    else if (mi >= body_len) tag = "R4";
    else tag = "R9";
    chk(mi < 0, tag, $sformatf("vec%0d byte %0d", idx, mi),
        (mi < 0) ? 0 : int'(ob[mi]), (mi < 0) ? 0 : int'(eb[mi]));

    // Error marking
    exp_err = (int'(v.len) >= 9 && int'(v.len) <= 13) || v.err;
    tag = v.err ? "R8" : "R7";
    chk(oerr == exp_err, tag, $sformatf("vec%0d errctl", idx), int'(oerr), int'(exp_err));

    // Framing flags
    chk(!oframe_bad, "R9", $sformatf("vec%0d sop/eop/empty framing", idx), int'(oframe_bad), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #3000000;
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state held in reset and right after release
    chk(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);

    for (int i = 0; i < NV; i++) run_vector(VECS[i], i);

    // R1: stall behaviour seen across all back-pressured vectors
    chk(r1_bad == 0, "R1", "output hold / input stall violations", r1_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule